// File: doc/BRIEF.md
# PHY Reset and Mode Setup Sequencer

This block runs once after every hard or soft reset. It brings an external PHY into a known state by sending management write requests to a separate MDIO frame engine. Each request carries a register address and a 16-bit data word. The frame engine accepts a request by returning a one-cycle acknowledge.

Five control inputs choose which frames are sent:

- a dormant-mode bit,
- a PHY-reset request,
- an auto-negotiation enable,
- a forced full-duplex bit,
- a "port scan active" qualifier.

The control values are sampled in the first cycle of the sequence, so later changes do not affect the sequence that is already running.

When a reset frame is needed, it goes out first. The block then waits a programmable settle time before it writes the mode frame. A one-cycle done pulse marks the end of the last frame. In dormant mode the block sends nothing and waits until the next soft reset.

Top module: `phy_setup_seq`

## Requirements
- R1: While `rstN` is low, `wrReq` and `setupDone` are 0. The sequence starts at the first clock edge after `rstN` rises, so `wrReq` is 1 in the cycle after that edge.
- R2: If `disableAuto` is 1 when the sequence starts, no request is raised and no done pulse is given until the next soft reset.
- R3: If `portScan` and `phyRstReq` are both 1 at the start, the first frame is the reset frame. It targets register 0 (`wrAddr` = 0) with data 16'h8000, where bit 15 is the PHY reset bit.
- R4: After the edge at which the reset frame's acknowledge is sampled, `wrReq` stays low for `settleCycles`+1 cycles. It then rises for the mode frame.
- R5: Every sequence that is not dormant ends with a mode frame to register 0. Its bit 12 (auto-negotiation enable) equals `aneEn` AND `portScan`.
- R6: Bit 8 (full duplex) of the mode frame equals `fullDup` when bit 12 is 0, and is 0 when bit 12 is 1. All other bits of the mode frame are 0.
- R7: While `portScan` is 0 at the start, `phyRstReq` has no effect: no reset frame is sent.
- R8: A raised request keeps `wrReq`, `wrAddr` and `wrData` stable until an acknowledge is sampled with it.
- R9: `setupDone` is high for exactly the one cycle after the edge at which the last frame's acknowledge is sampled.
- R10: A `softRst` pulse at any time drops any pending request. A new sequence then starts at the following edge, using the control values sampled at that edge. Control changes made after the start do not alter the running sequence.
- R11: A `wrAck` that arrives while no request is raised has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Hard reset, asynchronous, active low |
| softRst | input | 1 | Soft reset pulse, synchronous, active high |
| disableAuto | input | 1 | Stay dormant after reset |
| phyRstReq | input | 1 | Send a PHY reset frame (needs `portScan`) |
| aneEn | input | 1 | Enable auto-negotiation in the PHY (needs `portScan`) |
| fullDup | input | 1 | Force full duplex when auto-negotiation is off |
| portScan | input | 1 | Port scan active qualifier |
| settleCycles | input | SETTLE_W | Settle wait after the reset frame |
| wrReq | output | 1 | Write request to the frame engine |
| wrAddr | output | ADDR_W | PHY register address of the request |
| wrData | output | DATA_W | Data of the request |
| wrAck | input | 1 | Acknowledge from the frame engine |
| setupDone | output | 1 | One-cycle pulse after the last frame |

## Verification
The hardest case to reach from the ports is a soft reset that arrives part-way through a sequence, together with control values that change after the start.

The stimulus reaches this case in steps:

1. Start a reset-plus-mode sequence with a long settle time.
2. Flip `aneEn` while the reset frame is still waiting for its acknowledge.
3. Pulse `softRst` inside the settle window, so the aborted run has to give way to a fresh run that uses the new values.

Stray acknowledges are injected while the block is idle. Acknowledge latency is varied so that the hold-until-acknowledge behaviour is exercised.

// File: rtl/physeq_pkg.sv
package physeq_pkg;

  typedef enum logic [2:0] {
    S_START,
    S_IDLE,
    S_RSTW,
    S_SETTLE,
    S_MODEW
  } seqState_t;

  typedef struct packed {
    logic latchCfg;
    logic loadRst;
    logic loadMode;
    logic clrReq;
    logic loadSettle;
    logic decSettle;
    logic pulseDone;
  } seqStrobe_t;

endpackage

// File: rtl/physeq_ctrl.sv
module physeq_ctrl
  import physeq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       softRst,
  input  logic       disableAuto,
  input  logic       phyRstReq,
  input  logic       portScan,
  input  logic       wrAck,
  input  logic       settleZero,
  input  logic       wrReq,
  output seqStrobe_t st
);

  seqState_t state, nextState;

  always_comb begin
    nextState = state;
    st = '0;
    if (softRst) begin
      st.clrReq = 1'b1;
      nextState = S_START;
    end else begin
      unique case (state)
        S_START: begin
          st.latchCfg = 1'b1;
          if (disableAuto) begin
            nextState = S_IDLE;
          end else if (portScan && phyRstReq) begin
            st.loadRst = 1'b1;
            nextState = S_RSTW;
          end else begin
            st.loadMode = 1'b1;
            nextState = S_MODEW;
          end
        end
        S_RSTW: begin
          if (wrAck) begin
            st.clrReq = 1'b1;
            st.loadSettle = 1'b1;
            nextState = S_SETTLE;
          end
        end
        S_SETTLE: begin
          if (settleZero) begin
            st.loadMode = 1'b1;
            nextState = S_MODEW;
          end else begin
            st.decSettle = 1'b1;
          end
        end
        S_MODEW: begin
          if (wrAck) begin
            st.clrReq = 1'b1;
            st.pulseDone = 1'b1;
            nextState = S_IDLE;
          end
        end
        default: nextState = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_START;
    else       state <= nextState;
  end

  // R2: once idle, no request appears without a soft reset
  p_dormant_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && !softRst) |=> !wrReq);

endmodule

// File: rtl/physeq_dp.sv
module physeq_dp
  import physeq_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 5,
  parameter int SETTLE_W = 8,
  parameter int CTRL_REG = 0,
  parameter int RST_BIT  = 15,
  parameter int ANE_BIT  = 12,
  parameter int FD_BIT   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          st,
  input  logic                softRst,
  input  logic                aneEn,
  input  logic                fullDup,
  input  logic                portScan,
  input  logic [SETTLE_W-1:0] settleCycles,
  input  logic                wrAck,
  output logic                wrReq,
  output logic [ADDR_W-1:0]   wrAddr,
  output logic [DATA_W-1:0]   wrData,
  output logic                setupDone,
  output logic                settleZero
);

  localparam logic [DATA_W-1:0] RST_WORD = DATA_W'(1) << RST_BIT;

  logic [DATA_W-1:0]   modeNow, modeHeld;
  logic [SETTLE_W-1:0] settleCnt;
  logic                aneEff;

  always_comb begin
    aneEff = aneEn && portScan;
    modeNow = '0;
    modeNow[ANE_BIT] = aneEff;
    modeNow[FD_BIT]  = fullDup && !aneEff;
  end

  assign wrAddr     = ADDR_W'(CTRL_REG);
  assign settleZero = (settleCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrReq     <= 1'b0;
      wrData    <= '0;
      modeHeld  <= '0;
      settleCnt <= '0;
      setupDone <= 1'b0;
    end else begin
      if (st.latchCfg) modeHeld <= modeNow;
      if (st.loadRst) begin
        wrReq  <= 1'b1;
        wrData <= RST_WORD;
      end else if (st.loadMode) begin
        wrReq  <= 1'b1;
        wrData <= st.latchCfg ? modeNow : modeHeld;
      end else if (st.clrReq) begin
        wrReq <= 1'b0;
      end
      if (st.loadSettle)     settleCnt <= settleCycles;
      else if (st.decSettle) settleCnt <= settleCnt - 1'b1;
      setupDone <= st.pulseDone;
    end
  end

  // R8: request and data held until acknowledged
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && !wrAck && !softRst) |=> (wrReq && $stable(wrData)));

  // R6: full duplex never accompanies auto-negotiation enable
  p_fd_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |-> !(wrData[ANE_BIT] && wrData[FD_BIT]));

  // R9: done is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    setupDone |=> !setupDone);

  // R9: done follows an accepted frame
  p_done_after_ack_r9: assert property (@(posedge clk) disable iff (!rstN)
    setupDone |-> $past(wrReq && wrAck));

endmodule

// File: rtl/phy_setup_seq.sv
module phy_setup_seq
  import physeq_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 5,
  parameter int SETTLE_W = 8,
  parameter int CTRL_REG = 0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                softRst,
  input  logic                disableAuto,
  input  logic                phyRstReq,
  input  logic                aneEn,
  input  logic                fullDup,
  input  logic                portScan,
  input  logic [SETTLE_W-1:0] settleCycles,
  output logic                wrReq,
  output logic [ADDR_W-1:0]   wrAddr,
  output logic [DATA_W-1:0]   wrData,
  input  logic                wrAck,
  output logic                setupDone
);

  seqStrobe_t st;
  logic       settleZero;

  physeq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .softRst(softRst), .disableAuto(disableAuto),
    .phyRstReq(phyRstReq), .portScan(portScan), .wrAck(wrAck),
    .settleZero(settleZero), .wrReq(wrReq), .st(st)
  );

  physeq_dp #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SETTLE_W(SETTLE_W), .CTRL_REG(CTRL_REG)
  ) i_dp (
    .clk(clk), .rstN(rstN), .st(st), .softRst(softRst), .aneEn(aneEn),
    .fullDup(fullDup), .portScan(portScan), .settleCycles(settleCycles),
    .wrAck(wrAck), .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData),
    .setupDone(setupDone), .settleZero(settleZero)
  );

endmodule

// File: tb/test_phy_setup_seq.sv
module test_phy_setup_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        softRst = 1'b0;
  logic        disableAuto = 1'b0, phyRstReq = 1'b0, aneEn = 1'b0;
  logic        fullDup = 1'b0, portScan = 1'b0;
  logic [7:0]  settleCycles = 8'd0;
  logic        wrReq, setupDone;
  logic [4:0]  wrAddr;
  logic [15:0] wrData;
  logic        wrAck = 1'b0;
  logic        strayAck = 1'b0;
  logic        ackLine;

  int compared = 0, mismatched = 0;
  int ackLat = 0, reqWait = 0, doneCnt = 0, cycles = 0;
  string curTag = "R1";
  logic [15:0] seen[$];

  // reference model state
  logic        mReq = 1'b0, mDone = 1'b0, mStart = 1'b1, mAne;
  logic [15:0] mData = '0;
  int          mGap = -1;
  logic [15:0] mQ[$];

  assign ackLine = wrAck | strayAck;

  phy_setup_seq i_phy_setup_seq (
    .clk(clk), .rstN(rstN), .softRst(softRst), .disableAuto(disableAuto),
    .phyRstReq(phyRstReq), .aneEn(aneEn), .fullDup(fullDup),
    .portScan(portScan), .settleCycles(settleCycles), .wrReq(wrReq),
    .wrAddr(wrAddr), .wrData(wrData), .wrAck(ackLine), .setupDone(setupDone)
  );

  always #2 clk = ~clk;

  task automatic check(input string tag, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mReq = 0; mDone = 0; mStart = 1; mGap = -1; mQ.delete();
    end else begin
      if (wrReq && ackLine && !softRst) seen.push_back(wrData);
      mDone = 0;
      if (softRst) begin
        mQ.delete(); mReq = 0; mStart = 1; mGap = -1;
      end else if (mStart) begin
        mStart = 0;
        if (!disableAuto) begin
          if (portScan && phyRstReq) mQ.push_back(16'h8000);
          mAne = portScan && aneEn;
          mQ.push_back({3'b0, mAne, 3'b0, fullDup && !mAne, 8'h00});
          mData = mQ.pop_front();
          mReq = 1;
        end
      end else if (mReq && ackLine) begin
        mReq = 0;
        if (mQ.size() > 0) mGap = int'(settleCycles);
        else mDone = 1;
      end else if (mGap >= 0) begin
        if (mGap == 0) begin
          mData = mQ.pop_front(); mReq = 1; mGap = -1;
        end else mGap--;
      end
    end
  end

  always @(negedge clk) begin
    check(curTag, "wrReq", int'(wrReq), int'(mReq));
    check("R9", "setupDone", int'(setupDone), int'(mDone));
    if (mReq) begin
      check(curTag, "wrData", int'(wrData), int'(mData));
      check("R3", "wrAddr", int'(wrAddr), 0);
    end
    if (setupDone) doneCnt++;
    if (wrReq) begin
      wrAck <= (reqWait >= ackLat);
      reqWait++;
    end else begin
      wrAck <= 1'b0;
      reqWait = 0;
    end
  end

  initial begin
    wait (cycles > 100000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  task automatic pulseSoft();
    @(negedge clk); softRst = 1'b1;
    @(negedge clk); softRst = 1'b0;
    seen.delete(); doneCnt = 0;
  endtask

  task automatic finishScen(input string tag, input int nExp,
                            input logic [15:0] e0, input logic [15:0] e1, input int expDone);
    repeat (50) @(negedge clk);
    check(tag, "frameCount", seen.size(), nExp);
    if (nExp > 0 && seen.size() > 0) check(tag, "frame0", int'(seen[0]), int'(e0));
    if (nExp > 1 && seen.size() > 1) check(tag, "frame1", int'(seen[1]), int'(e1));
    check(tag, "doneCount", doneCnt, expDone);
  endtask

  task automatic runScen(input string tag, input logic dis, input logic rq,
                         input logic an, input logic fd, input logic ps,
                         input int settle, input int lat, input int nExp,
                         input logic [15:0] e0, input logic [15:0] e1, input int expDone);
    @(negedge clk);
    curTag = tag;
    disableAuto = dis; phyRstReq = rq; aneEn = an; fullDup = fd; portScan = ps;
    settleCycles = 8'(settle); ackLat = lat;
    pulseSoft();
    finishScen(tag, nExp, e0, e1, expDone);
  endtask

  initial begin
    // R1: reset state, then default sequence
    repeat (3) @(negedge clk);
    check("R1", "wrReq in reset", int'(wrReq), 0);
    check("R1", "setupDone in reset", int'(setupDone), 0);
    rstN = 1'b1;
    finishScen("R1", 1, 16'h0000, 16'h0000, 1);

    runScen("R3", 0, 1, 1, 0, 1, 3, 2, 2, 16'h8000, 16'h1000, 1);
    runScen("R4", 0, 1, 0, 0, 1, 0, 0, 2, 16'h8000, 16'h0000, 1);
    runScen("R4", 0, 1, 0, 1, 1, 5, 1, 2, 16'h8000, 16'h0100, 1);
    runScen("R6", 0, 0, 0, 1, 1, 2, 0, 1, 16'h0100, 16'h0000, 1);
    runScen("R6", 0, 0, 1, 1, 1, 2, 0, 1, 16'h1000, 16'h0000, 1);
    runScen("R5", 0, 0, 1, 0, 0, 2, 1, 1, 16'h0000, 16'h0000, 1);
    runScen("R7", 0, 1, 1, 1, 0, 2, 0, 1, 16'h0100, 16'h0000, 1);
    runScen("R8", 0, 1, 1, 0, 1, 1, 6, 2, 16'h8000, 16'h1000, 1);
    runScen("R2", 1, 1, 1, 1, 1, 0, 0, 0, 16'h0000, 16'h0000, 0);

    // R11: stray acks while idle after the dormant run
    curTag = "R11";
    repeat (3) begin
      @(negedge clk); strayAck = 1'b1;
      @(negedge clk); strayAck = 1'b0;
    end
    finishScen("R11", 0, 16'h0000, 16'h0000, 0);

    // R10: configuration change after start is not seen
    @(negedge clk);
    curTag = "R10";
    disableAuto = 0; phyRstReq = 1; aneEn = 1; fullDup = 0; portScan = 1;
    settleCycles = 8'd4; ackLat = 4;
    pulseSoft();
    @(negedge clk); aneEn = 1'b0; fullDup = 1'b1;
    finishScen("R10", 2, 16'h8000, 16'h1000, 1);

    // R10: soft reset inside the settle window restarts with new values
    @(negedge clk);
    aneEn = 1; fullDup = 0; settleCycles = 8'd20; ackLat = 0;
    pulseSoft();
    repeat (6) @(negedge clk);
    aneEn = 1'b0; fullDup = 1'b1; settleCycles = 8'd1;
    pulseSoft();
    finishScen("R10", 2, 16'h8000, 16'h0100, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule